// File: doc/BRIEF.md
# Programmable-Tick Line Glitch Filter

This block cleans up one asynchronous bus line before protocol logic sees it. A typical use is an open-drain consumer-electronics control line, which idles high. The raw line first passes through a two-stage synchronizer. The block also produces a periodic tick whose base comes from a 2-bit select. The filtered output takes a new level only after the synchronized line has held that level for `delay × 3` ticks.

The tick base is either three system clocks or one, ten or a hundred microseconds. The microsecond base counts `CLKS_PER_US` system clocks. Any pulse that lasts fewer than `delay × 3` ticks is discarded. A delay of 0 turns filtering off, and the synchronized line then drives the output directly. Each time the filtered output changes level, a one-cycle strobe marks the change.

The block has no data stream. The line is a level, so there is no valid/ready handshake and no back-pressure. All pins are plain control and status signals.

Top module: `line_glitch_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_o` is 1 (idle level) and `edge_o` is 0.
- R2: With `delay_i` = 0 the filter is bypassed. `line_o` follows `line_i` with a latency of three clock edges (two synchronizer flops and the output flop), so even a two-cycle pulse appears at the output.
- R3: `tick_sel_i` = 0 produces a tick every 3 system clocks.
- R4: `tick_sel_i` = 1, 2 and 3 produce a tick every `CLKS_PER_US`, 10×`CLKS_PER_US` and 100×`CLKS_PER_US` system clocks.
- R5: When `delay_i` is nonzero, the output ignores a level that lasts at most `(delay×3 − 1) × P − 1` clocks, where P is the tick period in clocks.
- R6: When `delay_i` is nonzero, the output takes a level that has lasted `delay×3 × P + 4` clocks. This holds for falling and rising transitions alike.
- R7: The stability count restarts when the synchronized line returns to the output level, even for a single cycle. Two sub-threshold pulses separated by a one-cycle blip are therefore both rejected.
- R8: `edge_o` is high for exactly one cycle, in the same cycle that `line_o` takes its new value, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_i | input | 1 | Raw asynchronous line |
| tick_sel_i | input | 2 | Tick base: 0 = 3 clocks, 1 = 1 µs, 2 = 10 µs, 3 = 100 µs |
| delay_i | input | DLY_W | Stability threshold in units of 3 ticks; 0 bypasses the filter |
| line_o | output | 1 | Filtered line level |
| edge_o | output | 1 | One-cycle strobe on each change of `line_o` |

## Verification
The assertions assume that `tick_sel_i` and `delay_i` change only while the synchronized line equals the filtered output. If they changed during a count, the threshold would move mid-count. The stimulus always reconfigures while the line idles high, after the filter has settled. The raw line is treated as asynchronous by the design, but the stimulus drives it only on falling clock edges, so synchronizer metastability never has to be modelled. Pulse widths are chosen a full tick clear of each threshold, so the unknown tick phase cannot change the result.

// File: rtl/lgf_pkg.sv
package lgf_pkg;
  typedef enum logic [1:0] {
    TICK_3CLK  = 2'd0,
    TICK_1US   = 2'd1,
    TICK_10US  = 2'd2,
    TICK_100US = 2'd3
  } tick_sel_e;

  localparam int unsigned BASE_DIV   = 3;
  localparam int unsigned DECADE_DIV = 10;
  localparam int unsigned NUM_DEC    = 3;
  localparam logic        LINE_IDLE  = 1'b1;
endpackage

// File: rtl/lgf_sync.sv
module lgf_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[0] <= RESET_VAL;
          else       chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[s] <= RESET_VAL;
          else       chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lgf_tick_gen.sv
module lgf_tick_gen
  import lgf_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 24
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned BASE_W = $clog2(BASE_DIV);
  localparam int unsigned US_W   = $clog2(CLKS_PER_US);
  localparam int unsigned DEC_W  = $clog2(DECADE_DIV);

  logic [BASE_W-1:0] base_q;
  logic              base_tick;
  logic [US_W-1:0]   us_q;
  logic [NUM_DEC-1:0] dec_tick;

  // three-clock base
  always_ff @(posedge clk_i) begin
    if (rst_i)                               base_q <= '0;
    else if (base_q == BASE_W'(BASE_DIV-1))  base_q <= '0;
    else                                     base_q <= base_q + 1'b1;
  end
  assign base_tick = (base_q == BASE_W'(BASE_DIV-1));

  // microsecond prescaler
  always_ff @(posedge clk_i) begin
    if (rst_i)                                us_q <= '0;
    else if (us_q == US_W'(CLKS_PER_US-1))    us_q <= '0;
    else                                      us_q <= us_q + 1'b1;
  end
  assign dec_tick[0] = (us_q == US_W'(CLKS_PER_US-1));

  // decade chain: each stage divides the previous tick by ten
  generate
    for (genvar d = 1; d < NUM_DEC; d++) begin : g_dec
      logic [DEC_W-1:0] cnt_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else if (dec_tick[d-1]) begin
          if (cnt_q == DEC_W'(DECADE_DIV-1)) cnt_q <= '0;
          else                               cnt_q <= cnt_q + 1'b1;
        end
      end
      assign dec_tick[d] = dec_tick[d-1] && (cnt_q == DEC_W'(DECADE_DIV-1));

      a_r4_decade_nested: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_tick[d] |-> dec_tick[d-1]);
    end
  endgenerate

  always_comb begin
    unique case (tick_sel_e'(sel_i))
      TICK_3CLK:  tick_o = base_tick;
      TICK_1US:   tick_o = dec_tick[0];
      TICK_10US:  tick_o = dec_tick[1];
      TICK_100US: tick_o = dec_tick[2];
      default:    tick_o = base_tick;
    endcase
  end

  a_r3_base_gap: assert property (@(posedge clk_i) disable iff (rst_i)
    base_tick |=> !base_tick ##1 !base_tick);
  a_r4_us_gap: assert property (@(posedge clk_i) disable iff (rst_i)
    dec_tick[0] |=> !dec_tick[0]);
endmodule

// File: rtl/lgf_stable_filter.sv
module lgf_stable_filter
  import lgf_pkg::*;
#(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sync_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             filt_o,
  output logic             chg_o
);
  localparam int unsigned CNT_W = DLY_W + 2;

  logic             filt_q, chg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt_inc;

  assign thr     = CNT_W'(dly_i) * CNT_W'(3);
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      filt_q <= LINE_IDLE;
      chg_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      chg_q <= 1'b0;
      if (dly_i == '0) begin
        cnt_q <= '0;
        if (sync_i != filt_q) begin
          filt_q <= sync_i;
          chg_q  <= 1'b1;
        end
      end else if (sync_i == filt_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_inc >= thr) begin
          filt_q <= sync_i;
          chg_q  <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign filt_o = filt_q;
  assign chg_o  = chg_q;

  a_r1_reset_idle: assert property (@(posedge clk_i)
    rst_i |=> (filt_q == LINE_IDLE) && !chg_q);
  a_r2_bypass: assert property (@(posedge clk_i) disable iff (rst_i)
    (dly_i == '0) |=> (filt_q == $past(sync_i)));
  a_r6_moves_to_sync: assert property (@(posedge clk_i) disable iff (rst_i)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_i)));
  a_r7_restart: assert property (@(posedge clk_i) disable iff (rst_i)
    (sync_i == filt_q) |=> (cnt_q == '0));
  a_r8_strobe_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    (filt_q != $past(filt_q)) |-> chg_q);
  a_r8_strobe_only_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    chg_q |-> (filt_q != $past(filt_q)));
endmodule

// File: rtl/line_glitch_filter.sv
module line_glitch_filter
  import lgf_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 24,
  parameter int unsigned DLY_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             line_i,
  input  logic [1:0]       tick_sel_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             line_o,
  output logic             edge_o
);
  logic line_sync;
  logic tick;

  lgf_sync #(.STAGES(2), .RESET_VAL(LINE_IDLE)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (line_i),
    .sync_o  (line_sync)
  );

  lgf_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sel_i  (tick_sel_i),
    .tick_o (tick)
  );

  lgf_stable_filter #(.DLY_W(DLY_W)) u_filt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sync_i (line_sync),
    .tick_i (tick),
    .dly_i  (delay_i),
    .filt_o (line_o),
    .chg_o  (edge_o)
  );
endmodule

// File: tb/sim_line_glitch_filter.sv
`timescale 1ns/1ps
module sim_line_glitch_filter;
  localparam int CPU = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_in = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [2:0] dly = 3'd0;
  logic       line_out, edge_out;

  int n_chk = 0, n_fail = 0;
  int edges = 0, strobes = 0;
  logic prev_out = 1'b1;

  always #4 clk = ~clk;

  line_glitch_filter #(.CLKS_PER_US(CPU), .DLY_W(3)) u0 (
    .clk_i(clk), .rst_i(rst), .line_i(line_in), .tick_sel_i(sel),
    .delay_i(dly), .line_o(line_out), .edge_o(edge_out)
  );

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (line_out !== prev_out) edges = edges + 1;
      if (edge_out) strobes = strobes + 1;
    end
    prev_out = line_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input logic [1:0] s);
    case (s)
      2'd0: return 3;
      2'd1: return CPU;
      2'd2: return CPU * 10;
      default: return CPU * 100;
    endcase
  endfunction

  task automatic hold(input logic lvl, input int n);
    line_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [1:0] s, input logic [2:0] d);
    sel = s; dly = d;
    hold(1'b1, period(s) * 24 + 10);
  endtask

  // R1
  task automatic t_reset();
    check(line_out === 1'b1, "R1 line_o after reset", int'(line_out), 1);
    check(edge_out === 1'b0, "R1 edge_o after reset", int'(edge_out), 0);
  endtask

  // R2: bypass with delay 0
  task automatic t_bypass();
    int e0, s0;
    configure(2'd0, 3'd0);
    e0 = edges; s0 = strobes;
    line_in = 1'b0;
    repeat (2) @(negedge clk);
    check(line_out === 1'b1, "R2 no change before third edge", int'(line_out), 1);
    @(negedge clk);
    check(line_out === 1'b0, "R2 low on third edge", int'(line_out), 0);
    hold(1'b0, 0);
    line_in = 1'b1;
    repeat (5) @(negedge clk);
    check(edges - e0 == 2, "R2 short pulse passed", edges - e0, 2);
    check(strobes - s0 == 2, "R8 strobe per bypass edge", strobes - s0, 2);
  endtask

  // R5 (and R3/R4 through the tick period)
  task automatic t_reject(input logic [1:0] s, input logic [2:0] d, input string req);
    int p, thr, e0, s0;
    configure(s, d);
    p = period(s); thr = 3 * d;
    e0 = edges; s0 = strobes;
    hold(1'b0, (thr - 1) * p - 1);
    hold(1'b1, thr * p + 8);
    check(edges - e0 == 0, {req, " R5 short low pulse ignored"}, edges - e0, 0);
    check(strobes - s0 == 0, {req, " R8 no strobe on rejected pulse"}, strobes - s0, 0);
  endtask

  // R6 (and R3/R4)
  task automatic t_accept(input logic [1:0] s, input logic [2:0] d, input string req);
    int p, thr, e0, s0;
    configure(s, d);
    p = period(s); thr = 3 * d;
    e0 = edges; s0 = strobes;
    hold(1'b0, thr * p + 4);
    check(line_out === 1'b0, {req, " R6 falling level taken"}, int'(line_out), 0);
    check(strobes - s0 == 1, {req, " R8 one strobe on fall"}, strobes - s0, 1);
    hold(1'b1, thr * p + 4);
    check(line_out === 1'b1, {req, " R6 rising level taken"}, int'(line_out), 1);
    check(edges - e0 == 2 && strobes - s0 == 2, {req, " R8 strobes match edges"},
          strobes - s0, edges - e0);
  endtask

  // R7: one-cycle blip restarts the count
  task automatic t_restart();
    int e0;
    configure(2'd0, 3'd2);
    e0 = edges;
    hold(1'b0, 14);
    hold(1'b1, 1);
    hold(1'b0, 14);
    hold(1'b1, 40);
    check(edges - e0 == 0, "R7 blip restarts stability count", edges - e0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_reject(2'd0, 3'd1, "R3");
    t_accept(2'd0, 3'd1, "R3");
    t_reject(2'd1, 3'd7, "R4 1us");
    t_accept(2'd1, 3'd7, "R4 1us");
    t_reject(2'd2, 3'd2, "R4 10us");
    t_accept(2'd2, 3'd2, "R4 10us");
    t_reject(2'd3, 3'd1, "R4 100us");
    t_accept(2'd3, 3'd1, "R4 100us");
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule